// File: doc/BRIEF.md
# Mouse Motion Packet Queue

This block converts pointing-device events into a fixed five-byte report and stores the bytes in an on-chip byte queue for a host to drain. An event carries signed horizontal and vertical motion and the state of three buttons. The block accepts an event in one cycle, latches its encoded report, and then writes the five report bytes into the queue on five consecutive cycles. It refuses further events while those writes are in progress.

The host takes one byte per read strobe. The byte appears on the read port one cycle after the strobe. A level output tells the host whether at least one byte is waiting. When the queue has no free entry, further bytes are dropped without notice. A clear strobe empties the queue at once.

Top module: `mouse_pkt_queue`

## Requirements
- R1: Report byte 0 is 0x87 with a bit cleared for each pressed button: left clears bit 2, middle clears bit 1, right clears bit 0.
- R2: Report byte 1 is the horizontal motion, a MOTION_W-bit two's-complement value, saturated to the range -127..+127 and given as an 8-bit two's-complement value. Values above +127 give 0x7F and values below -127 give 0x81.
- R3: Report byte 2 is the negated vertical motion, saturated in the same way. The negation is done at full width, so the most negative input gives 0x7F.
- R4: Report bytes 3 and 4 are 0x00. An event sampled with evtValid and evtReady both high at clock edge k pushes bytes 0..4 at edges k+1..k+5. evtReady is low from edge k until edge k+5. An event offered while evtReady is low is ignored.
- R5: The queue is first-in first-out, with 2**DEPTH_LOG2 entries (256 by default) and wrapping pointers. dataAvail is high exactly when the queue holds at least one byte.
- R6: A rdStrobe sampled at edge k removes the oldest byte and presents it on rdData after edge k. If the queue is empty, rdData becomes 0x00. rdData holds its value when there is no read.
- R7: A byte pushed while the queue holds 2**DEPTH_LOG2 bytes is discarded. If an event finds fewer than five free entries, its leading bytes fill the queue and the rest are lost.
- R8: clrStrobe empties the queue and discards any report bytes not yet pushed. It takes priority over a push and a read in the same cycle, and evtReady is high after it.
- R9: A read and a push in the same cycle both take effect, and the byte order is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evtValid | input | 1 | Event strobe |
| evtReady | output | 1 | High when a new event can be accepted |
| evtDx | input | MOTION_W | Horizontal motion, two's complement |
| evtDy | input | MOTION_W | Vertical motion, two's complement |
| btnLeft | input | 1 | Left button pressed |
| btnMid | input | 1 | Middle button pressed |
| btnRight | input | 1 | Right button pressed |
| rdStrobe | input | 1 | Host read request |
| rdData | output | 8 | Byte returned by the last read |
| dataAvail | output | 1 | Queue holds at least one byte |
| clrStrobe | input | 1 | Empty the queue |

## Verification
The bench builds the block with its default parameters: 10-bit motion and a 256-entry queue. The 10-bit motion inputs allow both positive and negative saturation. They also allow the negation of -512, which does not fit in 10 bits. A full-depth queue is reached with 52 reports. The 52nd report leaves a single byte in the last free entry and drops the remaining four. Draining that queue then makes both pointers wrap before a further report is checked.

// File: rtl/mpq_pkg.sv
package mpq_pkg;
  localparam int PKT_BYTES = 5;
  localparam int SEL_W     = 3;

  typedef struct packed {
    logic             capture;  // latch encoded report
    logic             push;     // write selected byte to queue
    logic             pop;      // read oldest byte
    logic             zeroRd;   // read of empty queue
    logic             clr;      // empty queue
    logic [SEL_W-1:0] byteSel;  // report byte being pushed
  } mpqStrobes_t;
endpackage

// File: rtl/mpq_encoder.sv
module mpq_encoder #(
  parameter int MOTION_W = 10
) (
  input  logic [MOTION_W-1:0] dx,
  input  logic [MOTION_W-1:0] dy,
  input  logic                btnLeft,
  input  logic                btnMid,
  input  logic                btnRight,
  output logic [4:0][7:0]     pkt
);
  localparam int EXT_W = MOTION_W + 1;
  localparam logic signed [EXT_W-1:0] POS_LIM = EXT_W'(127);
  localparam logic signed [EXT_W-1:0] NEG_LIM = -POS_LIM;

  logic signed [EXT_W-1:0] dxExt;
  logic signed [EXT_W-1:0] dyNeg;

  function automatic logic [7:0] sat8(input logic signed [EXT_W-1:0] v);
    if (v > POS_LIM) return 8'h7F;
    if (v < NEG_LIM) return 8'h81;
    return v[7:0];
  endfunction

  always_comb begin
    dxExt  = signed'({dx[MOTION_W-1], dx});
    dyNeg  = -signed'({dy[MOTION_W-1], dy});
    pkt[0] = 8'h87 ^ {5'b00000, btnLeft, btnMid, btnRight};
    pkt[1] = sat8(dxExt);
    pkt[2] = sat8(dyNeg);
    pkt[3] = 8'h00;
    pkt[4] = 8'h00;
  end
endmodule

// File: rtl/mpq_ctrl.sv
module mpq_ctrl
  import mpq_pkg::*;
#(
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  evtValid,
  input  logic                  rdStrobe,
  input  logic                  clrStrobe,
  output mpqStrobes_t           strobes,
  output logic [DEPTH_LOG2-1:0] wrAddr,
  output logic [DEPTH_LOG2-1:0] rdAddr,
  output logic                  evtReady,
  output logic                  dataAvail
);
  localparam int CNT_W = DEPTH_LOG2 + 1;
  localparam int DEPTH = 1 << DEPTH_LOG2;
  localparam logic [SEL_W-1:0] LAST_SEL = SEL_W'(PKT_BYTES - 1);

  logic             active;
  logic [SEL_W-1:0] byteIdx;
  logic [CNT_W-1:0] fillCnt;
  logic             isFull;
  logic             isEmpty;

  assign isFull  = (fillCnt == CNT_W'(DEPTH));
  assign isEmpty = (fillCnt == '0);

  always_comb begin
    strobes.clr     = clrStrobe;
    strobes.capture = evtValid && !active && !clrStrobe;
    strobes.push    = active && !clrStrobe && !isFull;
    strobes.pop     = rdStrobe && !clrStrobe && !isEmpty;
    strobes.zeroRd  = rdStrobe && !clrStrobe && isEmpty;
    strobes.byteSel = byteIdx;
  end

  // report serializer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      byteIdx <= '0;
    end else if (clrStrobe) begin
      active  <= 1'b0;
      byteIdx <= '0;
    end else if (strobes.capture) begin
      active  <= 1'b1;
      byteIdx <= '0;
    end else if (active) begin
      if (byteIdx == LAST_SEL) begin
        active  <= 1'b0;
        byteIdx <= '0;
      end else begin
        byteIdx <= byteIdx + 1'b1;
      end
    end
  end

  // queue pointers and fill level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrAddr  <= '0;
      rdAddr  <= '0;
      fillCnt <= '0;
    end else if (clrStrobe) begin
      wrAddr  <= '0;
      rdAddr  <= '0;
      fillCnt <= '0;
    end else begin
      if (strobes.push) wrAddr <= wrAddr + 1'b1;
      if (strobes.pop)  rdAddr <= rdAddr + 1'b1;
      case ({strobes.push, strobes.pop})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  assign evtReady  = !active;
  assign dataAvail = !isEmpty;
endmodule

// File: rtl/mpq_datapath.sv
module mpq_datapath
  import mpq_pkg::*;
#(
  parameter int MOTION_W   = 10,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  mpqStrobes_t           strobes,
  input  logic [DEPTH_LOG2-1:0] wrAddr,
  input  logic [DEPTH_LOG2-1:0] rdAddr,
  input  logic [MOTION_W-1:0]   evtDx,
  input  logic [MOTION_W-1:0]   evtDy,
  input  logic                  btnLeft,
  input  logic                  btnMid,
  input  logic                  btnRight,
  output logic [7:0]            rdData
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [4:0][7:0] encPkt;
  logic [4:0][7:0] pktReg;
  logic [7:0]      wrByte;
  logic [7:0]      store [DEPTH];

  mpq_encoder #(.MOTION_W(MOTION_W)) u_enc (
    .dx(evtDx), .dy(evtDy),
    .btnLeft(btnLeft), .btnMid(btnMid), .btnRight(btnRight),
    .pkt(encPkt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               pktReg <= '0;
    else if (strobes.capture) pktReg <= encPkt;
  end

  assign wrByte = pktReg[strobes.byteSel];

  always_ff @(posedge clk) begin
    if (strobes.push) store[wrAddr] <= wrByte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              rdData <= 8'h00;
    else if (strobes.pop)    rdData <= store[rdAddr];
    else if (strobes.zeroRd) rdData <= 8'h00;
  end
endmodule

// File: rtl/mouse_pkt_queue.sv
module mouse_pkt_queue
  import mpq_pkg::*;
#(
  parameter int MOTION_W   = 10,
  parameter int DEPTH_LOG2 = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                evtValid,
  output logic                evtReady,
  input  logic [MOTION_W-1:0] evtDx,
  input  logic [MOTION_W-1:0] evtDy,
  input  logic                btnLeft,
  input  logic                btnMid,
  input  logic                btnRight,
  input  logic                rdStrobe,
  output logic [7:0]          rdData,
  output logic                dataAvail,
  input  logic                clrStrobe
);
  mpqStrobes_t           strobes;
  logic [DEPTH_LOG2-1:0] wrAddr;
  logic [DEPTH_LOG2-1:0] rdAddr;

  mpq_ctrl #(.DEPTH_LOG2(DEPTH_LOG2)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .evtValid(evtValid), .rdStrobe(rdStrobe), .clrStrobe(clrStrobe),
    .strobes(strobes), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .evtReady(evtReady), .dataAvail(dataAvail)
  );

  mpq_datapath #(.MOTION_W(MOTION_W), .DEPTH_LOG2(DEPTH_LOG2)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobes(strobes),
    .wrAddr(wrAddr), .rdAddr(rdAddr),
    .evtDx(evtDx), .evtDy(evtDy),
    .btnLeft(btnLeft), .btnMid(btnMid), .btnRight(btnRight),
    .rdData(rdData)
  );
endmodule

// File: rtl/mpq_checker.sv
module mpq_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       evtValid,
  input logic       evtReady,
  input logic       rdStrobe,
  input logic [7:0] rdData,
  input logic       dataAvail,
  input logic       clrStrobe
);
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStrobe && !dataAvail && !clrStrobe) |=> (rdData == 8'h00)); // R6
  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rdStrobe |=> $stable(rdData)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clrStrobe |=> (!dataAvail && evtReady)); // R8
  AST_AVAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (dataAvail && !rdStrobe && !clrStrobe) |=> dataAvail); // R5
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (evtValid && evtReady && !clrStrobe) |=> !evtReady); // R4
  AST_AVAIL_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dataAvail) |-> $past(!evtReady)); // R5
endmodule

bind mouse_pkt_queue mpq_checker chk_i (
  .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtReady(evtReady),
  .rdStrobe(rdStrobe), .rdData(rdData), .dataAvail(dataAvail),
  .clrStrobe(clrStrobe)
);

// File: tb/mouse_pkt_queue_tb.sv
module mouse_pkt_queue_tb_top;
  localparam int MW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          evtValid = 1'b0;
  logic          evtReady;
  logic [MW-1:0] evtDx = '0;
  logic [MW-1:0] evtDy = '0;
  logic          btnLeft = 1'b0, btnMid = 1'b0, btnRight = 1'b0;
  logic          rdStrobe = 1'b0;
  logic [7:0]    rdData;
  logic          dataAvail;
  logic          clrStrobe = 1'b0;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always #5 clk = ~clk;

  mouse_pkt_queue #(.MOTION_W(MW), .DEPTH_LOG2(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .evtValid(evtValid), .evtReady(evtReady),
    .evtDx(evtDx), .evtDy(evtDy), .btnLeft(btnLeft), .btnMid(btnMid),
    .btnRight(btnRight), .rdStrobe(rdStrobe), .rdData(rdData),
    .dataAvail(dataAvail), .clrStrobe(clrStrobe)
  );

  // {dx, dy, buttons L/M/R, expected bytes 0..4}
  localparam logic [62:0] VECS [6] = '{
    {10'h005, 10'h003, 3'b000, 40'h8705FD0000},
    {10'h0C8, 10'h2D4, 3'b100, 40'h837F7F0000},
    {10'h200, 10'h1FF, 3'b010, 40'h8581810000},
    {10'h381, 10'h380, 3'b001, 40'h86817F0000},
    {10'h07F, 10'h07F, 3'b111, 40'h807F810000},
    {10'h000, 10'h3FF, 3'b000, 40'h8700010000}
  };

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic sendEvent(input logic [MW-1:0] dx, input logic [MW-1:0] dy, input logic [2:0] btn);
    @(negedge clk);
    while (!evtReady) @(negedge clk);
    evtDx = dx; evtDy = dy; {btnLeft, btnMid, btnRight} = btn;
    evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  task automatic doRead(output logic [7:0] v);
    @(negedge clk);
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    v = rdData;
  endtask

  function automatic logic [7:0] vecByte(input logic [62:0] v, input int p);
    return v[39 - 8*p -: 8];
  endfunction

  initial begin
    logic [7:0] got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk1("R5 reset dataAvail", dataAvail, 1'b0);
    chk1("R4 reset evtReady", evtReady, 1'b1);
    chk8("R6 reset rdData", rdData, 8'h00);

    // empty read
    doRead(got);
    chk8("R6 empty read", got, 8'h00);

    // vector table: R1 R2 R3 R4
    for (int i = 0; i < 6; i++) begin
      sendEvent(VECS[i][62:53], VECS[i][52:43], VECS[i][42:40]);
      repeat (5) @(negedge clk);
      chk1("R5 avail after report", dataAvail, 1'b1);
      for (int p = 0; p < 5; p++) begin
        doRead(got);
        chk8($sformatf("R1/R2/R3/R4 vec%0d byte%0d", i, p), got, vecByte(VECS[i], p));
      end
      chk1("R5 empty after drain", dataAvail, 1'b0);
    end

    // R4 event during busy is ignored
    sendEvent(VECS[0][62:53], VECS[0][52:43], VECS[0][42:40]);
    chk1("R4 busy after accept", evtReady, 1'b0);
    evtDx = 10'h011; evtValid = 1'b1;
    @(negedge clk);
    evtValid = 1'b0;
    repeat (5) @(negedge clk);
    for (int p = 0; p < 5; p++) begin
      doRead(got);
      chk8("R4 ignored event byte", got, vecByte(VECS[0], p));
    end
    chk1("R4 no extra bytes", dataAvail, 1'b0);

    // R9 concurrent read and push
    sendEvent(VECS[1][62:53], VECS[1][52:43], VECS[1][42:40]);
    @(negedge clk);
    rdStrobe = 1'b1;
    for (int p = 0; p < 5; p++) begin
      @(negedge clk);
      chk8("R9 concurrent byte", rdData, vecByte(VECS[1], p));
    end
    rdStrobe = 1'b0;
    chk1("R9 empty after concurrent", dataAvail, 1'b0);

    // R7 fill queue: 52 reports, last partial
    for (int e = 0; e < 52; e++) sendEvent(MW'(e), 10'h001, 3'b000);
    repeat (6) @(negedge clk);
    for (int j = 0; j < 256; j++) begin
      logic [7:0] exp;
      case (j % 5)
        0: exp = 8'h87;
        1: exp = 8'(j / 5);
        2: exp = 8'hFF;
        default: exp = 8'h00;
      endcase
      doRead(got);
      chk8($sformatf("R7 full queue byte%0d", j), got, exp);
    end
    chk1("R7 overflow dropped", dataAvail, 1'b0);

    // R5 pointer wrap
    sendEvent(VECS[2][62:53], VECS[2][52:43], VECS[2][42:40]);
    repeat (5) @(negedge clk);
    for (int p = 0; p < 5; p++) begin
      doRead(got);
      chk8("R5 wrapped byte", got, vecByte(VECS[2], p));
    end

    // R8 clear mid-report
    sendEvent(VECS[3][62:53], VECS[3][52:43], VECS[3][42:40]);
    repeat (2) @(negedge clk);
    chk1("R8 bytes present before clear", dataAvail, 1'b1);
    clrStrobe = 1'b1;
    @(negedge clk);
    clrStrobe = 1'b0;
    chk1("R8 empty after clear", dataAvail, 1'b0);
    chk1("R8 ready after clear", evtReady, 1'b1);
    repeat (4) @(negedge clk);
    chk1("R8 pending bytes discarded", dataAvail, 1'b0);
    doRead(got);
    chk8("R8 read after clear", got, 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule